// File: doc/BRIEF.md
# Staircase Mesh Route Unit

This unit computes the output port for a packet at one router of a mesh built from chips stacked in a staircase. The nodes of that mesh lie in a slanted band rather than in a rectangle. Columns run from X = 0 to X = 2N. In column X, the valid rows run from Y = X - 2M up to Y = X. The band is therefore 2N+1 nodes wide and 2M+1 nodes tall. Coordinates are signed, because rows below the base row are negative.

For each request, the unit receives the current node and the destination node. One clock later it returns a one-hot port choice:

- local
- +X
- -X
- +Y
- -Y

It keeps the X-before-Y order of plain dimension-order routing. When the next X step would leave the band, the unit sends the packet one step along the band edge in Y instead, and X movement resumes at the next node.

Every step it picks shortens the Manhattan distance by one. A full route therefore takes exactly as many hops as plain dimension-order routing. The turns the unit takes are limited to the following, which keeps the ring of channel dependencies open:

- +X to +Y and back
- -X to -Y and back
- X to Y once the column matches

Top module: `stair_route_unit`

## Requirements
- R1: While rst_n is low, and in the first cycle after its release, rsp_valid is 0 and port_sel is all zeros.
- R2: rsp_valid equals req_valid from the previous clock. In a cycle after one with req_valid low, port_sel keeps its value whatever the coordinate inputs do.
- R3: port_sel is local (bit 0) exactly when the current node equals the destination in both coordinates.
- R4: When the destination column is greater than the current column and node (cur_x+1, cur_y) is in the band, port_sel is +X (bit 1). A node (x,y) is in the band when 0 <= x <= 2N and x-2M <= y <= x.
- R5: When the destination column is smaller than the current column and (cur_x-1, cur_y) is in the band, port_sel is -X (bit 2).
- R6: When an eastward move is needed but (cur_x+1, cur_y) lies below the band's lower edge, port_sel is +Y (bit 3).
- R7: When a westward move is needed but (cur_x-1, cur_y) lies above the band's upper edge, port_sel is -Y (bit 4).
- R8: When the columns match and the rows differ, port_sel is +Y if dst_y > cur_y and -Y otherwise.
- R9: Whenever rsp_valid is high, exactly one bit of port_sel is set.
- R10: Every non-local step lands on a node in the band and reduces the Manhattan distance to the destination by one. A route therefore takes |dx-cx| + |dy-cy| hops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Coordinates on the inputs are to be routed this cycle |
| cur_x | input | CW | Current node column, signed |
| cur_y | input | CW | Current node row, signed |
| dst_x | input | CW | Destination column, signed |
| dst_y | input | CW | Destination row, signed |
| rsp_valid | output | 1 | port_sel holds the result of the previous cycle's request |
| port_sel | output | 5 | One-hot port: bit0 local, bit1 +X, bit2 -X, bit3 +Y, bit4 -Y |

## Verification
The landing and distance properties assume that both the current and the destination node of a request lie inside the band. Outside the band, a choice that stays in the band and shortens the distance may not exist. Those properties are therefore gated on a band test of the sampled inputs.

The stimulus enumerates only in-band nodes, once as a back-to-back stream of every ordered pair and once as hop-by-hop walks. Each walk moves the current node according to the port the unit returns, so a correct unit never leaves the band.

// File: rtl/stair_route_pkg.sv
package stair_route_pkg;

  localparam int NPORT   = 5;
  localparam int P_LOCAL = 0;
  localparam int P_XP    = 1;
  localparam int P_XN    = 2;
  localparam int P_YP    = 3;
  localparam int P_YN    = 4;

  // Band membership: columns 0..2n, rows between the two diagonals.
  function automatic logic in_region(input int x, input int y, input int n, input int m);
    return (x >= 0) && (x <= 2*n) && (y >= x - 2*m) && (y <= x);
  endfunction

  function automatic int hop_dist(input int ax, input int ay, input int bx, input int by);
    int ddx;
    int ddy;
    ddx = (ax > bx) ? ax - bx : bx - ax;
    ddy = (ay > by) ? ay - by : by - ay;
    return ddx + ddy;
  endfunction

endpackage

// File: rtl/stair_route_core.sv
module stair_route_core
  import stair_route_pkg::*;
#(
  parameter int N  = 5,
  parameter int M  = 2,
  parameter int CW = 6
) (
  input  logic signed [CW-1:0] cur_x,
  input  logic signed [CW-1:0] cur_y,
  input  logic signed [CW-1:0] dst_x,
  input  logic signed [CW-1:0] dst_y,
  output logic [NPORT-1:0]     port_d
);

  int cx;
  int cy;
  int tx;
  int ty;
  logic east_ok;
  logic west_ok;

  assign cx = int'(cur_x);
  assign cy = int'(cur_y);
  assign tx = int'(dst_x);
  assign ty = int'(dst_y);

  // Is the neighbouring node in X still inside the staircase band?
  assign east_ok = in_region(cx + 1, cy, N, M);
  assign west_ok = in_region(cx - 1, cy, N, M);

  always_comb begin
    port_d = '0;
    if (cx == tx && cy == ty) begin
      port_d[P_LOCAL] = 1'b1;
    end else if (tx > cx) begin
      // blocked at the lower edge: climb along the edge first
      port_d[east_ok ? P_XP : P_YP] = 1'b1;
    end else if (tx < cx) begin
      // blocked at the upper edge: descend along the edge first
      port_d[west_ok ? P_XN : P_YN] = 1'b1;
    end else begin
      port_d[(ty > cy) ? P_YP : P_YN] = 1'b1;
    end
  end

endmodule

// File: rtl/stair_route_reg.sv
module stair_route_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic         valid_q,
  output logic [W-1:0] q
);

  logic         valid_nxt;
  logic [W-1:0] q_nxt;

  always_comb begin
    valid_nxt = en;
    q_nxt     = en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      q       <= '0;
    end else begin
      valid_q <= valid_nxt;
      q       <= q_nxt;
    end
  end

endmodule

// File: rtl/stair_route_unit.sv
module stair_route_unit
  import stair_route_pkg::*;
#(
  parameter int N  = 5,
  parameter int M  = 2,
  parameter int CW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic signed [CW-1:0] cur_x,
  input  logic signed [CW-1:0] cur_y,
  input  logic signed [CW-1:0] dst_x,
  input  logic signed [CW-1:0] dst_y,
  output logic                 rsp_valid,
  output logic [NPORT-1:0]     port_sel
);

  logic [NPORT-1:0] port_d;

  stair_route_core #(.N(N), .M(M), .CW(CW)) u_core (
    .cur_x (cur_x),
    .cur_y (cur_y),
    .dst_x (dst_x),
    .dst_y (dst_y),
    .port_d(port_d)
  );

  stair_route_reg #(.W(NPORT)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (req_valid),
    .d      (port_d),
    .valid_q(rsp_valid),
    .q      (port_sel)
  );

  // Request endpoints both inside the band (assumption gate for checks).
  logic req_in_band;
  assign req_in_band = in_region(int'(cur_x), int'(cur_y), N, M) &&
                       in_region(int'(dst_x), int'(dst_y), N, M);

  // R9
  onehot_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(port_sel) == 1));

  // R3
  local_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (port_sel[P_LOCAL] ==
      (($past(cur_x) == $past(dst_x)) && ($past(cur_y) == $past(dst_y)))));

  // R10
  step_in_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_in_band)) |->
      in_region(int'($past(cur_x)) + int'(port_sel[P_XP]) - int'(port_sel[P_XN]),
                int'($past(cur_y)) + int'(port_sel[P_YP]) - int'(port_sel[P_YN]), N, M));

  // R10
  step_closer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_in_band) && !port_sel[P_LOCAL]) |->
      (hop_dist(int'($past(cur_x)) + int'(port_sel[P_XP]) - int'(port_sel[P_XN]),
                int'($past(cur_y)) + int'(port_sel[P_YP]) - int'(port_sel[P_YN]),
                int'($past(dst_x)), int'($past(dst_y))) + 1 ==
       hop_dist(int'($past(cur_x)), int'($past(cur_y)),
                int'($past(dst_x)), int'($past(dst_y)))));

  // R8
  same_col_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ($past(cur_x) == $past(dst_x))) |->
      (!port_sel[P_XP] && !port_sel[P_XN]));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid && $past(rst_n)) |=> (rsp_valid || $stable(port_sel)));

endmodule

// File: tb/stair_route_unit_tb.sv
`timescale 1ns/1ps
module stair_route_unit_tb;

  localparam int N  = 5;
  localparam int M  = 2;
  localparam int CW = 6;

  logic clk;
  logic rst_n;
  logic req_valid;
  logic signed [CW-1:0] cur_x, cur_y, dst_x, dst_y;
  logic rsp_valid;
  logic [4:0] port_sel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  stair_route_unit #(.N(N), .M(M), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .rsp_valid(rsp_valid), .port_sel(port_sel)
  );

  function automatic bit band(int x, int y);
    return x >= 0 && x <= 2*N && y >= x - 2*M && y <= x;
  endfunction

  // Behavioural reference: expected port and the requirement it exercises.
  function automatic int model(int cx, int cy, int tx, int ty, output string tag);
    if (cx == tx && cy == ty) begin tag = "R3"; return 1; end
    if (tx > cx) begin
      if (band(cx + 1, cy)) begin tag = "R4"; return 2; end
      tag = "R6"; return 8;
    end
    if (tx < cx) begin
      if (band(cx - 1, cy)) begin tag = "R5"; return 4; end
      tag = "R7"; return 16;
    end
    tag = "R8";
    return (ty > cy) ? 8 : 16;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(bit v, int cx, int cy, int tx, int ty);
    req_valid = v;
    cur_x = CW'(cx); cur_y = CW'(cy);
    dst_x = CW'(tx); dst_y = CW'(ty);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int nx[$];
  int ny[$];

  initial begin
    string tag;
    int exp_p;
    bit have_prev;
    int prev_exp;
    string prev_tag;

    for (int x = 0; x <= 2*N; x++)
      for (int y = x - 2*M; y <= x; y++) begin
        nx.push_back(x); ny.push_back(y);
      end

    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
    check(port_sel == 5'd0, "R1", "port_sel in reset", port_sel, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0 && port_sel == 5'd0, "R1", "after release",
          {rsp_valid, port_sel}, 0);

    // Streaming phase: a new request every clock, compared on the next.
    have_prev = 0;
    prev_exp = 0;
    prev_tag = "";
    foreach (nx[a]) begin
      foreach (nx[b]) begin
        @(negedge clk);
        if (have_prev) begin
          check(rsp_valid == 1'b1, "R2", "rsp_valid streaming", rsp_valid, 1);
          check(port_sel == 5'(prev_exp), prev_tag, "stream port", port_sel, prev_exp);
        end
        exp_p = model(nx[a], ny[a], nx[b], ny[b], tag);
        drive(1, nx[a], ny[a], nx[b], ny[b]);
        prev_exp = exp_p; prev_tag = tag; have_prev = 1;
      end
    end
    @(negedge clk);
    check(port_sel == 5'(prev_exp), prev_tag, "last stream port", port_sel, prev_exp);
    drive(0, 0, 0, 10, 10);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(rsp_valid == 1'b0, "R2", "rsp_valid idle", rsp_valid, 0);
      check(port_sel == 5'(prev_exp), "R2", "port held while idle", port_sel, prev_exp);
      drive(0, k, k - 1, 10 - k, 6);
    end

    // Walk phase: follow the returned port hop by hop.
    foreach (nx[a]) begin
      foreach (nx[b]) begin
        int x;
        int y;
        int hops;
        int p;
        x = nx[a]; y = ny[a]; hops = 0;
        for (int step = 0; step < 40; step++) begin
          @(negedge clk);
          drive(1, x, y, nx[b], ny[b]);
          exp_p = model(x, y, nx[b], ny[b], tag);
          @(negedge clk);
          p = int'(port_sel);
          check($countones(port_sel) == 1, "R9", "one-hot", p, exp_p);
          check(p == exp_p, tag, "walk port", p, exp_p);
          if (p == 1) break;
          if (p == 2) x++;
          else if (p == 4) x--;
          else if (p == 8) y++;
          else y--;
          hops++;
          if (!band(x, y)) begin
            check(0, "R10", "left band at x", x, y);
            break;
          end
        end
        check(hops == ((nx[b] > nx[a]) ? nx[b] - nx[a] : nx[a] - nx[b]) +
                      ((ny[b] > ny[a]) ? ny[b] - ny[a] : ny[a] - ny[b]),
              "R10", "hop count", hops,
              ((nx[b] > nx[a]) ? nx[b] - nx[a] : nx[a] - nx[b]) +
              ((ny[b] > ny[a]) ? ny[b] - ny[a] : ny[a] - ny[b]));
      end
    end
    @(negedge clk);
    drive(0, 0, 0, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule